// File: doc/BRIEF.md
# Masked Receive Address Filter

This block sits behind the byte stage of a serial frame receiver and decides whether a frame is meant for this station. Software loads four 8-bit station addresses and two 8-bit don't-care masks through a small register-write port and selects single-byte or two-byte addressing. The receiver streams in the address bytes of each frame and flags the final one. One cycle after that final byte, the filter pulses a verdict that says accept or reject, together with a flag that marks an all-ones (broadcast) address.

In single-byte mode, a frame passes when its address byte equals any one of the four station addresses. Mask A applies to station addresses 0 and 2, and mask B applies to 1 and 3. In two-byte mode, the first byte must equal station address 1 or station address 3 under mask B. The second byte must equal station address 2 under mask A. Station address 2 is therefore a shared low byte for two alternative high bytes. An address made only of 1 bits always passes. The mode bit and all six registers are captured when the first address byte of a frame is taken, so a write made during reception applies from the next frame onward.

The byte input is a valid/ready stream. `in_ready` is held high at all times, so the filter never applies back-pressure and takes a byte on every cycle in which `in_valid` is high. The sender may insert idle cycles between bytes. `in_end` is looked at only together with `in_valid`.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, all four station addresses and both masks are 0x00, the mode is single-byte and no verdict is pending. A single-byte frame 0x00 is accepted and 0x01 is rejected.
- R2: In single-byte mode, the verdict is accept when the first address byte equals any of station addresses 0 to 3 after masking. Otherwise the verdict is reject.
- R3: In two-byte mode, the verdict is accept when byte 1 matches station address 1 or 3 and byte 2 matches station address 2. Every other pairing is rejected.
- R4: An all-ones address (0xFF in single-byte mode, 0xFF then 0xFF in two-byte mode) is accepted whatever the register contents. Such a verdict also raises `out_bcast`, and `out_bcast` is never high without `out_accept`.
- R5: A 1 in a mask bit removes that bit from the comparison. Mask A (select 4) applies to station addresses 0 and 2, and mask B (select 5) applies to station addresses 1 and 3, in both modes.
- R6: `out_valid` is high for exactly the one cycle that follows each byte taken with `in_end` high. `out_accept` and `out_bcast` are low whenever `out_valid` is low. Single-byte frames may end on consecutive cycles.
- R7: The mode bit and the six registers are sampled when the first byte of a frame is taken. A write in any later cycle of that frame does not change its verdict.
- R8: A two-byte-mode frame that ends on its first byte gives `out_valid` with `out_accept` and `out_bcast` low.
- R9: `in_ready` is always 1. Idle cycles between bytes do not change the verdict. Bytes after the address length (the first byte in single-byte mode, the first two in two-byte mode) are ignored until `in_end`.
- R10: A write with `cfg_sel` 0 to 3 loads the matching station address, 4 loads mask A, 5 loads mask B, and 6 loads the mode from `cfg_wdata[0]` (1 = two-byte). Select 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0-3 station address, 4 mask A, 5 mask B, 6 mode) |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Address byte present |
| in_ready | output | 1 | Always 1; filter accepts every offered byte |
| in_data | input | 8 | Address byte |
| in_end | input | 1 | Marks the last address byte of the frame |
| out_valid | output | 1 | One-cycle verdict strobe |
| out_accept | output | 1 | Verdict: frame addressed to this station |
| out_bcast | output | 1 | Verdict came from an all-ones address |

## Verification
The hardest case to reach is a register or mode write that lands between the first and last byte of a frame. The frame must still be judged by the captured settings, while the next frame uses the new ones. The bench places writes inside frames on purpose, including a mode flip in the middle of a two-byte frame. Randomised traffic also mixes writes, idle gaps, short frames and over-long frames from a small value set, so that matches, near-misses and all-ones bytes occur often. A behavioural model with a byte queue predicts every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_MATCH = 4;
  localparam int unsigned NUM_MASK  = 2;
  localparam int unsigned SEL_W     = 3;

  // register select codes
  localparam logic [SEL_W-1:0] SEL_MASK_A = 3'd4;
  localparam logic [SEL_W-1:0] SEL_MASK_B = 3'd5;
  localparam logic [SEL_W-1:0] SEL_MODE   = 3'd6;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic                        wide;   // 1 = two-byte addressing
    logic [NUM_MASK-1:0][BYTE_W-1:0]  mask;
    logic [NUM_MATCH-1:0][BYTE_W-1:0] match;
  } rxf_cfg_t;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  byte_t            wdata,
  output rxf_cfg_t         cfg
);
  localparam int unsigned MIDX_W = $clog2(NUM_MATCH);

  rxf_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      if (sel < SEL_W'(NUM_MATCH)) begin
        cfg_q.match[sel[MIDX_W-1:0]] <= wdata;
      end else if (sel == SEL_MASK_A) begin
        cfg_q.mask[0] <= wdata;
      end else if (sel == SEL_MASK_B) begin
        cfg_q.mask[1] <= wdata;
      end else if (sel == SEL_MODE) begin
        cfg_q.wide <= wdata[0];
      end
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/rxf_byte_match.sv
module rxf_byte_match
  import rxf_pkg::*;
(
  input  byte_t                  data,
  input  rxf_cfg_t               cfg,
  output logic [NUM_MATCH-1:0]   hit,
  output logic                   all_ones
);
  // Even station addresses use mask A, odd ones mask B; same in both modes.
  for (genvar gi = 0; gi < NUM_MATCH; gi++) begin : g_cmp
    localparam int unsigned MSEL = gi % NUM_MASK;
    byte_t diff;
    assign diff    = (data ^ cfg.match[gi]) & ~cfg.mask[MSEL];
    assign hit[gi] = (diff == '0);
  end

  assign all_ones = &data;
endmodule

// File: rtl/rxf_frame_ctrl.sv
module rxf_frame_ctrl
  import rxf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  rxf_cfg_t             live_cfg,
  output rxf_cfg_t             act_cfg,
  input  logic                 take,
  input  logic                 last,
  input  logic [NUM_MATCH-1:0] hit,
  input  logic                 all_ones,
  output logic                 out_valid,
  output logic                 out_accept,
  output logic                 out_bcast
);
  localparam int unsigned CNT_W = 2;
  localparam logic [CNT_W-1:0] IDX_SAT = 2'd2;

  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q;
  rxf_cfg_t         snap_q;

  // per-frame partial results
  logic f_hit8_q, f_hi_q, f_lo_q, f_ff0_q, f_ff1_q;
  logic vld_q, acc_q, bc_q;

  logic [CNT_W-1:0] idx;
  logic cur_hit8, cur_hi, cur_lo;
  logic hit8_v, ff0_v, lo_v, ff1_v, complete;
  logic bc_n, acc_n;

  assign act_cfg  = in_frame_q ? snap_q : live_cfg;
  assign idx      = in_frame_q ? cnt_q : '0;
  assign cur_hit8 = |hit;
  assign cur_hi   = hit[1] | hit[3];
  assign cur_lo   = hit[2];

  always_comb begin
    hit8_v   = (idx == '0) ? cur_hit8 : f_hit8_q;
    ff0_v    = (idx == '0) ? all_ones : f_ff0_q;
    lo_v     = (idx == 2'd1) ? cur_lo : f_lo_q;
    ff1_v    = (idx == 2'd1) ? all_ones : f_ff1_q;
    complete = (idx != '0);
    if (act_cfg.wide) begin
      bc_n  = complete & ff0_v & ff1_v;
      acc_n = bc_n | (complete & f_hi_q & lo_v);
    end else begin
      bc_n  = ff0_v;
      acc_n = bc_n | hit8_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      snap_q     <= '0;
      f_hit8_q   <= 1'b0;
      f_hi_q     <= 1'b0;
      f_lo_q     <= 1'b0;
      f_ff0_q    <= 1'b0;
      f_ff1_q    <= 1'b0;
      vld_q      <= 1'b0;
      acc_q      <= 1'b0;
      bc_q       <= 1'b0;
    end else begin
      vld_q <= take & last;
      acc_q <= take & last & acc_n;
      bc_q  <= take & last & bc_n;
      if (take) begin
        in_frame_q <= ~last;
        if (!in_frame_q) begin
          snap_q <= live_cfg;
          cnt_q  <= 2'd1;
        end else if (cnt_q != IDX_SAT) begin
          cnt_q <= cnt_q + 2'd1;
        end
        if (idx == '0) begin
          f_hit8_q <= cur_hit8;
          f_hi_q   <= cur_hi;
          f_ff0_q  <= all_ones;
        end
        if (idx == 2'd1) begin
          f_lo_q  <= cur_lo;
          f_ff1_q <= all_ones;
        end
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_accept = acc_q;
  assign out_bcast  = bc_q;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic             in_end,
  output logic             out_valid,
  output logic             out_accept,
  output logic             out_bcast
);
  rxf_cfg_t             live_cfg;
  rxf_cfg_t             act_cfg;
  logic [NUM_MATCH-1:0] hit;
  logic                 all_ones;
  logic                 take;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;

  rxf_cfg_regs i_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .cfg   (live_cfg)
  );

  rxf_byte_match i_match (
    .data     (in_data),
    .cfg      (act_cfg),
    .hit      (hit),
    .all_ones (all_ones)
  );

  rxf_frame_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .live_cfg   (live_cfg),
    .act_cfg    (act_cfg),
    .take       (take),
    .last       (in_end),
    .hit        (hit),
    .all_ones   (all_ones),
    .out_valid  (out_valid),
    .out_accept (out_accept),
    .out_bcast  (out_bcast)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic [BYTE_W-1:0] cfg_wdata,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_end,
  input logic             out_valid,
  input logic             out_accept,
  input logic             out_bcast,
  input rxf_cfg_t         live_cfg
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (live_cfg == '0));

  p_bcast_implies_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_bcast |-> (out_valid && out_accept));

  p_verdict_follows_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_end));

  p_end_gives_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_end) |=> out_valid);

  p_accept_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_accept |-> out_valid);

  p_ready_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == '0) |=> (live_cfg.match[0] == $past(cfg_wdata)));
endmodule

bind rx_addr_filter rxf_checker i_rxf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_end     (in_end),
  .out_valid  (out_valid),
  .out_accept (out_accept),
  .out_bcast  (out_bcast),
  .live_cfg   (live_cfg)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_end = 1'b0;
  logic       out_valid, out_accept, out_bcast;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string req = "R6";

  // reference model state
  byte unsigned m_match[4];
  byte unsigned m_mask[2];
  bit           m_wide;
  byte unsigned s_match[4];
  byte unsigned s_mask[2];
  bit           s_wide;
  bit           m_inframe;
  byte unsigned q[$];
  bit e_v, e_a, e_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_end(in_end), .out_valid(out_valid),
    .out_accept(out_accept), .out_bcast(out_bcast)
  );

  function automatic bit eq_m(byte unsigned x, int i);
    return ((x ^ s_match[i]) & ~s_mask[i % 2]) == 0;
  endfunction

  task automatic judge(output bit a, output bit b);
    if (s_wide) begin
      if (q.size() < 2) begin a = 0; b = 0; end
      else begin
        b = (q[0] == 8'hFF) && (q[1] == 8'hFF);
        a = b || ((eq_m(q[0], 1) || eq_m(q[0], 3)) && eq_m(q[1], 2));
      end
    end else begin
      b = (q[0] == 8'hFF);
      a = b;
      for (int i = 0; i < 4; i++) if (eq_m(q[0], i)) a = 1;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if ({out_valid, out_accept, out_bcast} !== {e_v, e_a, e_b}) begin
      errors++;
      $display("FAIL %s: got v/a/b=%b%b%b expected %b%b%b at %0t",
               tag, out_valid, out_accept, out_bcast, e_v, e_a, e_b, $time);
    end
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9: in_ready=%b expected 1", in_ready);
    end
  endtask

  // one clock: drive, predict, wait, compare (inputs change at negedge)
  task automatic step(bit we, logic [2:0] sel, logic [7:0] wd,
                      bit v, logic [7:0] d, bit e);
    bit a, b;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    in_valid = v; in_data = d; in_end = e;
    e_v = 0; e_a = 0; e_b = 0;
    if (v) begin
      if (!m_inframe) begin
        s_match = m_match; s_mask = m_mask; s_wide = m_wide;
        q.delete(); m_inframe = 1;
      end
      q.push_back(d);
      if (e) begin
        judge(a, b);
        e_v = 1; e_a = a; e_b = b; m_inframe = 0;
      end
    end
    if (we) begin
      if (sel < 4) m_match[sel] = wd;
      else if (sel == 4) m_mask[0] = wd;
      else if (sel == 5) m_mask[1] = wd;
      else if (sel == 6) m_wide = wd[0];
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    step(1, sel, d, 0, 8'h00, 0);
  endtask

  task automatic idle();
    step(0, 3'd0, 8'h00, 0, 8'h00, 0);
  endtask

  // single byte frame, with an explicit expected verdict as well
  task automatic f8(logic [7:0] d, bit exp_a, string tag);
    req = tag;
    step(0, 3'd0, 8'h00, 1, d, 1);
    checks++;
    if (out_accept !== exp_a) begin
      errors++;
      $display("FAIL %s: byte %h accept=%b expected %b", tag, d, out_accept, exp_a);
    end
  endtask

  task automatic f16(logic [7:0] h, logic [7:0] l, bit exp_a, string tag);
    req = tag;
    step(0, 3'd0, 8'h00, 1, h, 0);
    step(0, 3'd0, 8'h00, 1, l, 1);
    checks++;
    if (out_accept !== exp_a) begin
      errors++;
      $display("FAIL %s: pair %h%h accept=%b expected %b", tag, h, l, out_accept, exp_a);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (m_match[i]) m_match[i] = 0;
    foreach (m_mask[i]) m_mask[i] = 0;
    m_wide = 0; m_inframe = 0;
    repeat (3) @(negedge clk);
    e_v = 0; e_a = 0; e_b = 0;
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R1: cleared registers match 0x00
    f8(8'h00, 1, "R1");
    f8(8'h01, 0, "R1");

    // R10 / R2: program and hit each station address
    req = "R10";
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h56); wr(3'd3, 8'h78);
    f8(8'h12, 1, "R2"); f8(8'h34, 1, "R2");
    f8(8'h56, 1, "R2"); f8(8'h78, 1, "R2");
    f8(8'h99, 0, "R2"); f8(8'h00, 0, "R2");

    // R10: select 7 writes nothing
    req = "R10";
    wr(3'd7, 8'h99);
    f8(8'h99, 0, "R10");

    // R5: mask A on even, mask B on odd station addresses
    req = "R5";
    wr(3'd4, 8'h0F);
    f8(8'h1A, 1, "R5");   // near 0x12 under mask A
    f8(8'h3C, 0, "R5");   // near 0x34, mask A does not cover it
    wr(3'd5, 8'hF0);
    f8(8'h84, 1, "R5");   // near 0x34 under mask B
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    f8(8'h1A, 0, "R5");

    // R4: broadcast
    f8(8'hFF, 1, "R4");

    // R6: back-to-back single-byte frames
    f8(8'h12, 1, "R6"); f8(8'h13, 0, "R6"); f8(8'h78, 1, "R6");

    // R9: surplus bytes ignored in single-byte mode
    req = "R9";
    step(0, 0, 0, 1, 8'h56, 0); idle();
    step(0, 0, 0, 1, 8'h00, 0);
    step(0, 0, 0, 1, 8'h11, 1);

    // R3: two-byte mode
    req = "R10";
    wr(3'd6, 8'h01);
    f16(8'h34, 8'h56, 1, "R3");
    f16(8'h78, 8'h56, 1, "R3");
    f16(8'h12, 8'h56, 0, "R3");
    f16(8'h34, 8'h78, 0, "R3");
    f16(8'h56, 8'h34, 0, "R3");
    f16(8'hFF, 8'hFF, 1, "R4");
    f16(8'hFF, 8'h56, 0, "R4");
    // R5 in two-byte mode: mask B on byte 1, mask A on byte 2
    req = "R5";
    wr(3'd5, 8'h0F); wr(3'd4, 8'hF0);
    f16(8'h3B, 8'hA6, 1, "R5");
    wr(3'd5, 8'h00); wr(3'd4, 8'h00);

    // R8: short frame
    f8(8'h34, 0, "R8");
    f8(8'hFF, 0, "R8");

    // R9: gaps and over-long frame
    req = "R9";
    step(0, 0, 0, 1, 8'h78, 0); idle(); idle();
    step(0, 0, 0, 1, 8'h56, 0); idle();
    step(0, 0, 0, 1, 8'h00, 0);
    step(0, 0, 0, 1, 8'h00, 1);
    checks++;
    if (out_accept !== 1'b1) begin
      errors++;
      $display("FAIL R9: long frame accept=%b expected 1", out_accept);
    end

    // R7: writes during a frame do not affect it
    req = "R7";
    step(0, 0, 0, 1, 8'h34, 0);
    step(1, 3'd1, 8'h99, 0, 0, 0);
    step(1, 3'd6, 8'h00, 1, 8'h56, 0);
    step(1, 3'd2, 8'h11, 1, 8'h56, 1);
    checks++;
    if (out_accept !== 1'b1) begin
      errors++;
      $display("FAIL R7: mid-frame write changed verdict, accept=%b expected 1", out_accept);
    end
    f8(8'h99, 1, "R7");   // new value, single-byte mode now live
    f8(8'h34, 0, "R7");
    // write on the same cycle as the first byte is not seen
    req = "R7";
    step(1, 3'd0, 8'h21, 1, 8'h21, 1);
    checks++;
    if (out_accept !== 1'b0) begin
      errors++;
      $display("FAIL R7: same-cycle write used, accept=%b expected 0", out_accept);
    end

    // randomised mixed traffic, model compared every cycle
    req = "R2";
    for (int n = 0; n < 3000; n++) begin
      int r;
      byte unsigned pool[6];
      pool = '{8'h12, 8'h34, 8'h56, 8'hFF, 8'h00, 8'h35};
      r = $urandom_range(0, 99);
      if (r < 8) step(1, 3'($urandom_range(0, 7)), pool[$urandom_range(0, 5)], 0, 0, 0);
      else if (r < 12) step(1, 3'd4 + 3'($urandom_range(0, 1)),
                            8'($urandom_range(0, 3)), 0, 0, 0);
      else if (r < 30) idle();
      else step(($urandom_range(0, 9) == 0), 3'($urandom_range(0, 7)),
                pool[$urandom_range(0, 5)], 1, pool[$urandom_range(0, 5)],
                ($urandom_range(0, 2) == 0));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule